// File: doc/BRIEF.md
# Composite Raster Sync Timing Generator

This block produces the horizontal and vertical timing of a composite-video raster. Each time the slot enable is high it advances by one slot; a slot stands for four output pixel clocks. For every slot it reports what the line carries at that point: blanking, sync, colour burst or picture. It also keeps a slot counter and a line counter, and it pulses a line-end strobe and a field-start strobe when those counters wrap. In the picture part of a visible line it drives the background colour from the colour-0 input.

The vertical blanking interval occupies the first lines of each field. A short group of vertical-sync lines sits in the middle of that interval. Those lines use inverted polarity: sync is the long state and the short pulses are blank. When the field has an odd number of lines, the group starts and ends with half-line transition lines that change state at slot 113. This moves the group by half a line, so successive fields interlace.

Line length, field length and vertical-blank height are captured from the configuration inputs while reset is held. Their defaults are 227, 312 and 29.

A state register holds the kind of the current line, taking one of five states:
- `LK_ACTIVE`: a visible line.
- `LK_VB_PLAIN`: a normal blanking line.
- `LK_VB_INVERT`: an inverted sync line.
- `LK_VB_LEAD`: a blank-then-sync half line.
- `LK_VB_TRAIL`: a sync-then-blank half line.

The state is loaded at reset with the kind of line 0. It takes a new value only on the edge where the slot counter wraps, when it loads the kind of the line about to start. From any state, that line-wrap transition can lead to any other state.

Top module: `raster_sync_gen`

## Requirements
- R1: Reset state. While `rst_n` is low and after its release, slot and line are 0 and both strobes and `odd_field` are 0. The line 0 kind is in effect: with the default configuration, slot 0 reports blank.
- R2: Slot enable. When `slot_en` is low, the slot and line counters keep their values.
- R3: Visible line pattern. A line at or after the vertical-blank height reports, by slot:
  - slots 0–6: blank
  - slots 7–23: sync
  - slots 24–26: blank
  - slots 27–35: burst
  - slots 36–42: blank
  - slot 43 to the end of the line: picture

  The signal-kind encoding is 0 for blank, 1 for sync, 2 for burst and 3 for picture.
- R4: `pix_colour` equals `colour0` in picture slots and is 0 in every other slot.
- R5: Blanking line. A blanking line outside the sync group reports blank at slots 0–6, sync at slots 7–23 and blank for the rest of the line. It never reports burst.
- R6: Even field length. With midpoint m = vb_height >> 1, lines m-1, m and m+1 are inverted: sync at slots 0–6, blank at slots 7–23, sync for the rest of the line.
- R7: Odd field length.
  - Line m-1 is blank for slots 0–112 and sync from slot 113 on.
  - Line m+2 is sync for slots 0–112 and blank from slot 113 on.
  - Lines m and m+1 are inverted.
- R8: Line wrap. An enabled slot at slot line_len-1 wraps the slot counter to 0 and increments the line counter. `line_end` is high for exactly the one cycle that follows.
- R9: Field wrap. A wrap at line field_len-1 returns the line counter to 0. `field_start` is high in the same cycle as `line_end`.
- R10: Odd/even flag. `odd_field` toggles at every field wrap when the field length is odd, and stays 0 when it is even.
- R11: Configuration capture. The configuration inputs are sampled only while reset is held; changes to them after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration |
| slot_en | input | 1 | Advance one slot |
| cfg_line_len | input | 9 | Slots per line |
| cfg_field_len | input | 10 | Lines per field |
| cfg_vb_height | input | 6 | Vertical-blank lines at the top of the field |
| colour0 | input | 16 | Background colour for picture slots |
| sig_kind | output | 2 | 0 blank, 1 sync, 2 burst, 3 picture |
| pix_colour | output | 16 | Colour during picture, else 0 |
| slot_idx | output | 9 | Current slot in line |
| line_idx | output | 10 | Current line in field |
| line_end | output | 1 | One-cycle pulse after a line wrap |
| field_start | output | 1 | One-cycle pulse after a field wrap |
| odd_field | output | 1 | Field parity flag |

## Verification
The line-end and field-start strobes coincide when the last slot of the last line is enabled. In that same cycle the line-kind state switches from a visible line back to blanking, and the odd/even flag toggles. The bench provokes this by running a short odd-length field up to its final slot. It then judges the following cycle:
- both strobes are high
- line and slot read 0
- the flag has flipped
- slot 0 reports blank

It then checks that both strobes drop after one cycle without an enable.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [1:0] {
        SIG_BLANK = 2'd0,
        SIG_SYNC  = 2'd1,
        SIG_BURST = 2'd2,
        SIG_PICT  = 2'd3
    } sig_kind_t;

    typedef enum logic [2:0] {
        LK_ACTIVE,
        LK_VB_PLAIN,
        LK_VB_INVERT,
        LK_VB_LEAD,
        LK_VB_TRAIL
    } line_kind_t;

    // Slot boundaries: first slot of each segment
    localparam int HS_SYNC_AT  = 7;
    localparam int HS_BACK_AT  = 24;
    localparam int HS_BURST_AT = 27;
    localparam int HS_GAP_AT   = 36;
    localparam int HS_PICT_AT  = 43;
    localparam int HS_HALF_AT  = 113;
endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
    parameter int SLOT_W = 9,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic [SLOT_W-1:0] line_len,
    input  logic [LINE_W-1:0] field_len,
    output logic [SLOT_W-1:0] slot,
    output logic [LINE_W-1:0] line,
    output logic              line_adv,
    output logic [LINE_W-1:0] line_nx,
    output logic              line_end,
    output logic              field_start,
    output logic              odd_field
);
    logic last_slot, last_line;

    assign last_slot = (slot == line_len - SLOT_W'(1));
    assign last_line = (line == field_len - LINE_W'(1));
    assign line_adv  = slot_en && last_slot;
    assign line_nx   = last_line ? '0 : line + LINE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot        <= '0;
            line        <= '0;
            line_end    <= 1'b0;
            field_start <= 1'b0;
            odd_field   <= 1'b0;
        end else begin
            line_end    <= line_adv;
            field_start <= line_adv && last_line;
            if (slot_en)
                slot <= last_slot ? '0 : slot + SLOT_W'(1);
            if (line_adv)
                line <= line_nx;
            if (line_adv && last_line && field_len[0])
                odd_field <= ~odd_field;
        end
    end

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(slot) && $stable(line));
    a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> slot == '0);
    a_r9_field_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> line_end && line == '0);
    a_r10_even_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        !field_len[0] |-> !odd_field);
endmodule

// File: rtl/line_classifier.sv
module line_classifier
    import raster_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int VB_W   = 6
) (
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] field_len,
    input  logic [VB_W-1:0]   vb_height,
    output line_kind_t        kind
);
    localparam int CW = LINE_W + 1;
    logic [CW-1:0] ln, ln_p1, mid, vbh;

    assign ln    = CW'(line);
    assign ln_p1 = ln + CW'(1);
    assign vbh   = CW'(vb_height);
    assign mid   = CW'(vb_height >> 1);

    always_comb begin
        if (ln >= vbh)
            kind = LK_ACTIVE;
        else if (field_len[0]) begin
            if (ln_p1 == mid)
                kind = LK_VB_LEAD;
            else if (ln == mid + CW'(2))
                kind = LK_VB_TRAIL;
            else if (ln >= mid && ln <= mid + CW'(1))
                kind = LK_VB_INVERT;
            else
                kind = LK_VB_PLAIN;
        end else begin
            if (ln_p1 >= mid && ln <= mid + CW'(1))
                kind = LK_VB_INVERT;
            else
                kind = LK_VB_PLAIN;
        end
    end
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder
    import raster_pkg::*;
#(
    parameter int SLOT_W = 9
) (
    input  line_kind_t        kind,
    input  logic [SLOT_W-1:0] slot,
    output sig_kind_t         sig
);
    int s;
    assign s = int'(slot);

    always_comb begin
        unique case (kind)
            LK_ACTIVE: begin
                if (s < HS_SYNC_AT)       sig = SIG_BLANK;
                else if (s < HS_BACK_AT)  sig = SIG_SYNC;
                else if (s < HS_BURST_AT) sig = SIG_BLANK;
                else if (s < HS_GAP_AT)   sig = SIG_BURST;
                else if (s < HS_PICT_AT)  sig = SIG_BLANK;
                else                      sig = SIG_PICT;
            end
            LK_VB_PLAIN:
                sig = (s >= HS_SYNC_AT && s < HS_BACK_AT) ? SIG_SYNC : SIG_BLANK;
            LK_VB_INVERT:
                sig = (s >= HS_SYNC_AT && s < HS_BACK_AT) ? SIG_BLANK : SIG_SYNC;
            LK_VB_LEAD:
                sig = (s < HS_HALF_AT) ? SIG_BLANK : SIG_SYNC;
            LK_VB_TRAIL:
                sig = (s < HS_HALF_AT) ? SIG_SYNC : SIG_BLANK;
            default:
                sig = SIG_BLANK;
        endcase
    end
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import raster_pkg::*;
#(
    parameter int SLOT_W = 9,
    parameter int LINE_W = 10,
    parameter int VB_W   = 6,
    parameter int COL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic [SLOT_W-1:0] cfg_line_len,
    input  logic [LINE_W-1:0] cfg_field_len,
    input  logic [VB_W-1:0]   cfg_vb_height,
    input  logic [COL_W-1:0]  colour0,
    output logic [1:0]        sig_kind,
    output logic [COL_W-1:0]  pix_colour,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [LINE_W-1:0] line_idx,
    output logic              line_end,
    output logic              field_start,
    output logic              odd_field
);
    logic [SLOT_W-1:0] line_len_q;
    logic [LINE_W-1:0] field_len_q;
    logic [VB_W-1:0]   vb_height_q;
    logic              line_adv;
    logic [LINE_W-1:0] line_nx, cls_line, cls_field;
    logic [VB_W-1:0]   cls_vb;
    line_kind_t        cls_kind, kind_q;
    sig_kind_t         sig_w;

    // Configuration is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_len_q  <= cfg_line_len;
            field_len_q <= cfg_field_len;
            vb_height_q <= cfg_vb_height;
        end
    end

    raster_counters #(.SLOT_W(SLOT_W), .LINE_W(LINE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
        .line_len(line_len_q), .field_len(field_len_q),
        .slot(slot_idx), .line(line_idx),
        .line_adv(line_adv), .line_nx(line_nx),
        .line_end(line_end), .field_start(field_start),
        .odd_field(odd_field)
    );

    // During reset classify line 0 from the incoming configuration
    assign cls_line  = rst_n ? line_nx     : '0;
    assign cls_field = rst_n ? field_len_q : cfg_field_len;
    assign cls_vb    = rst_n ? vb_height_q : cfg_vb_height;

    line_classifier #(.LINE_W(LINE_W), .VB_W(VB_W)) u_cls (
        .line(cls_line), .field_len(cls_field), .vb_height(cls_vb),
        .kind(cls_kind)
    );

    // State register: line kind, transitions only on line wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            kind_q <= cls_kind;
        else if (line_adv)
            kind_q <= cls_kind;
    end

    slot_decoder #(.SLOT_W(SLOT_W)) u_dec (
        .kind(kind_q), .slot(slot_idx), .sig(sig_w)
    );

    // Output process
    always_comb begin
        sig_kind   = sig_w;
        pix_colour = (sig_w == SIG_PICT) ? colour0 : '0;
    end

    a_r3_burst_only_visible: assert property (@(posedge clk) disable iff (!rst_n)
        sig_kind == 2'd2 |-> kind_q == LK_ACTIVE);
    a_r4_pix_dark_outside_picture: assert property (@(posedge clk) disable iff (!rst_n)
        sig_kind != 2'd3 |-> pix_colour == '0);
    a_r8_kind_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(kind_q) |-> line_end);
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(line_len_q) && $stable(field_len_q) && $stable(vb_height_q));
endmodule

// File: tb/tb_raster_sync_gen.sv
module tb_raster_sync_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_en = 1'b0;
    logic [8:0]  cfg_line_len = 9'd227;
    logic [9:0]  cfg_field_len = 10'd312;
    logic [5:0]  cfg_vb_height = 6'd29;
    logic [15:0] colour0 = 16'h0ABC;
    logic [1:0]  sig_kind;
    logic [15:0] pix_colour;
    logic [8:0]  slot_idx;
    logic [9:0]  line_idx;
    logic        line_end, field_start, odd_field;

    int n_checks = 0;
    int n_errors = 0;
    int pos_l = 0, pos_s = 0, LL = 227, FL = 312;

    always #5 clk = ~clk;

    raster_sync_gen dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en),
        .cfg_line_len(cfg_line_len), .cfg_field_len(cfg_field_len),
        .cfg_vb_height(cfg_vb_height), .colour0(colour0),
        .sig_kind(sig_kind), .pix_colour(pix_colour),
        .slot_idx(slot_idx), .line_idx(line_idx),
        .line_end(line_end), .field_start(field_start), .odd_field(odd_field)
    );

    // Odd field of 41 lines, vb height 29, midpoint 14: {line, slot, kind}
    localparam int NV = 36;
    localparam int VEC [NV][3] = '{
        '{0, 0, 0}, '{0, 6, 0}, '{0, 7, 1}, '{0, 23, 1}, '{0, 24, 0}, '{0, 226, 0},
        '{13, 0, 0}, '{13, 112, 0}, '{13, 113, 1}, '{13, 226, 1},
        '{14, 0, 1}, '{14, 6, 1}, '{14, 7, 0}, '{14, 23, 0}, '{14, 24, 1},
        '{15, 100, 1},
        '{16, 0, 1}, '{16, 112, 1}, '{16, 113, 0},
        '{17, 7, 1}, '{17, 30, 0}, '{28, 226, 0},
        '{29, 0, 0}, '{29, 6, 0}, '{29, 7, 1}, '{29, 23, 1}, '{29, 24, 0}, '{29, 26, 0},
        '{29, 27, 2}, '{29, 35, 2}, '{29, 36, 0}, '{29, 42, 0}, '{29, 43, 3},
        '{29, 226, 3}, '{35, 100, 3}, '{40, 226, 3}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic en);
        slot_en = en;
        @(negedge clk);
        if (en) begin
            pos_s++;
            if (pos_s == LL) begin
                pos_s = 0;
                pos_l++;
                if (pos_l == FL) pos_l = 0;
            end
        end
        slot_en = 1'b0;
    endtask

    task automatic goto(input int l, input int s);
        while (!(pos_l == l && pos_s == s)) tick(1'b1);
    endtask

    task automatic do_reset(input int ll, input int fl, input int vb);
        rst_n = 1'b0;
        cfg_line_len = 9'(ll);
        cfg_field_len = 10'(fl);
        cfg_vb_height = 6'(vb);
        LL = ll; FL = fl;
        tick(1'b0);
        tick(1'b0);
        rst_n = 1'b1;
        pos_l = 0; pos_s = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: state while in reset and just after release
        do_reset(227, 312, 29);
        check("R1 slot", int'(slot_idx), 0);
        check("R1 line", int'(line_idx), 0);
        check("R1 strobes", int'({line_end, field_start, odd_field}), 0);
        check("R1 kind", int'(sig_kind), 0);
        // R2: no movement without enable
        goto(0, 10);
        repeat (5) tick(1'b0);
        check("R2 slot", int'(slot_idx), 10);
        check("R2 line", int'(line_idx), 0);
        // R11: config changes after reset are ignored; wrap still at 227
        cfg_line_len = 9'd100;
        cfg_field_len = 10'd5;
        goto(0, 226);
        check("R11 no early wrap", int'(line_idx), 0);
        tick(1'b1);
        check("R11 wrap slot", int'(slot_idx), 0);
        check("R8 line inc", int'(line_idx), 1);
        check("R8 line_end high", int'(line_end), 1);
        check("R9 no field_start", int'(field_start), 0);
        tick(1'b0);
        check("R8 line_end one cycle", int'(line_end), 0);

        // Odd field table walk
        do_reset(227, 41, 29);
        for (int i = 0; i < NV; i++) begin
            int l, s, k;
            string tag;
            l = VEC[i][0]; s = VEC[i][1]; k = VEC[i][2];
            goto(l, s);
            if (l >= 29) tag = "R3";
            else if (l >= 13 && l <= 16) tag = "R7";
            else tag = "R5";
            check(tag, int'(sig_kind), k);
            check("R4 colour", int'(pix_colour), (k == 3) ? 16'h0ABC : 0);
        end
        // R9 / R10: field wrap coincides with line end, flag toggles
        tick(1'b1);
        check("R9 line_end", int'(line_end), 1);
        check("R9 field_start", int'(field_start), 1);
        check("R9 line zero", int'(line_idx), 0);
        check("R10 odd flag set", int'(odd_field), 1);
        check("R5 slot0 blank after wrap", int'(sig_kind), 0);
        tick(1'b0);
        check("R9 strobes drop", int'({line_end, field_start}), 0);
        goto(40, 226);
        tick(1'b1);
        check("R10 odd flag clears", int'(odd_field), 0);

        // R6: even field, lines 13..15 inverted
        do_reset(227, 40, 29);
        goto(12, 0);  check("R6 line12 plain", int'(sig_kind), 0);
        goto(13, 0);  check("R6 line13 inv", int'(sig_kind), 1);
        goto(13, 10); check("R6 line13 inv gap", int'(sig_kind), 0);
        goto(14, 150); check("R6 line14 inv", int'(sig_kind), 1);
        goto(15, 200); check("R6 line15 inv", int'(sig_kind), 1);
        goto(16, 0);  check("R6 line16 plain", int'(sig_kind), 0);
        goto(16, 150); check("R5 line16 tail", int'(sig_kind), 0);
        goto(39, 226);
        tick(1'b1);
        check("R9 even field_start", int'(field_start), 1);
        check("R10 even flag stays", int'(odd_field), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule